// File: doc/BRIEF.md
# Coefficient Times Square Calculator

The block evaluates y = c[i] · x² on signed fixed-point words (8 integer bits, 12 fraction bits) with a single shared multiplier. The coefficients live in an on-chip 4096-entry table built as a synchronous RAM. This RAM registers its inputs and its read data, so a coefficient reaches the datapath two clock edges after its index is presented. A three-state Moore controller first squares x into the result register while the table read is in flight. It then multiplies that square by the coefficient and pulses a completion flag.

A side write port fills the table. It acts only while the controller is idle, and it takes priority over the index for the table address. A request is accepted on any idle cycle where the start strobe is high. Holding the strobe high runs back-to-back requests, one every three cycles.

Top module: `coef_square_calc`

## Requirements
- R1: While rst_ni is low and right after its release, y_o is 0 and done_o is 0, and the block is idle.
- R2: When start_i is high at a rising edge while idle, x_i and idx_i are captured on that edge. done_o goes high on the second rising edge after it and stays high for exactly one cycle.
- R3: While done_o is high, y_o equals trunc(c · trunc(x · x)). Here c is the table word at the captured index, and trunc takes bits 31 down to 12 of the full 40-bit signed product.
- R4: The truncation rounds toward negative infinity for negative products. Products beyond the 8.12 range wrap by keeping only those 20 bits.
- R5: start_i, x_i and idx_i are ignored during the two busy cycles after acceptance. The result is unchanged, and no extra done_o pulse follows.
- R6: y_o holds its value while the block is idle, until the next accepted request updates it.
- R7: With load_en_i high at a rising edge while idle, load_data_i is written to table entry load_addr_i. A request accepted on the very next edge already reads the new word.
- R8: load_en_i asserted during the busy cycles writes nothing. The table entry keeps its earlier contents.
- R9: When load_en_i and start_i are high on the same idle edge, the load wins the table address. The coefficient used is load_data_i, idx_i is ignored, and load_data_i is stored at load_addr_i.
- R10: With start_i held high, a new request is accepted on the idle cycle in which done_o is high. Results then come out every three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled while idle |
| x_i | input | 20 | Signed 8.12 operand x |
| idx_i | input | 12 | Coefficient table index |
| load_en_i | input | 1 | Table write enable, effective while idle |
| load_addr_i | input | 12 | Table write address |
| load_data_i | input | 20 | Signed 8.12 coefficient to write |
| y_o | output | 20 | Signed 8.12 result |
| done_o | output | 1 | One-cycle flag: y_o holds a fresh result |

## Verification
The assertions assume that rst_ni is released away from a clock edge and that inputs settle well before each rising edge. They also assume that only table entries written since reset are ever read, since unloaded entries hold undefined data. The bench drives every input on the falling edge and loads each index before any request uses it. It samples y_o and done_o on falling edges, which keeps the strobes and busy-time stimulus clear of the active edge.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {
    ST_CAPTURE = 2'b00,
    ST_SQUARE  = 2'b01,
    ST_SCALE   = 2'b10
  } csq_state_e;

  typedef struct packed {
    logic ram_en;
    logic x_ce;
    logic mul_sel;
    logic y_ce;
  } csq_ctrl_t;
endpackage

// File: rtl/csq_ctrl.sv
module csq_ctrl
  import csq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output csq_ctrl_t  ctrl_o,
  output csq_state_e state_o,
  output logic       done_o
);
  csq_state_e state_q, state_d;
  logic       done_q;

  always_comb begin
    state_d = state_q;
    ctrl_o  = '0;
    unique case (state_q)
      ST_CAPTURE: begin
        ctrl_o = '{ram_en: 1'b1, x_ce: 1'b1, mul_sel: 1'b0, y_ce: 1'b0};
        if (start_i) state_d = ST_SQUARE;
      end
      ST_SQUARE: begin
        ctrl_o  = '{ram_en: 1'b0, x_ce: 1'b0, mul_sel: 1'b0, y_ce: 1'b1};
        state_d = ST_SCALE;
      end
      ST_SCALE: begin
        ctrl_o  = '{ram_en: 1'b0, x_ce: 1'b0, mul_sel: 1'b1, y_ce: 1'b1};
        state_d = ST_CAPTURE;
      end
      default: state_d = ST_CAPTURE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CAPTURE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_SCALE);
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

  a_r2_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CAPTURE && start_i) |=> (state_q == ST_SQUARE));
  a_r5_square_to_scale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SQUARE) |=> (state_q == ST_SCALE));
  a_r10_scale_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCALE) |=> (state_q == ST_CAPTURE));
  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/csq_coef_ram.sv
// Synchronous RAM, registered inputs and registered read data.
module csq_coef_ram #(
  parameter int DATA_W = 20,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o
);
  localparam int Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [Depth];
  logic              en_q, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q, dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      din_q  <= '0;
    end else if (en_i) begin
      en_q   <= 1'b1;
      wr_q   <= wr_i;
      addr_q <= addr_i;
      din_q  <= din_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (en_q && wr_q) mem[addr_q] <= din_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dout_q <= '0;
    else if (en_q) dout_q <= wr_q ? din_q : mem[addr_q];
  end

  assign dout_o = dout_q;
endmodule

// File: rtl/csq_datapath.sv
module csq_datapath
  import csq_pkg::*;
#(
  parameter int DATA_W = 20,
  parameter int FRAC_W = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  csq_ctrl_t                ctrl_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] coef_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam int ProdW = 2 * DATA_W;
  localparam int KeepHi = FRAC_W + DATA_W - 1;

  logic signed [DATA_W-1:0] x_q, y_q, op_a, op_b;
  logic signed [ProdW-1:0]  prod;

  // square first (x*x), then scale by the late-arriving coefficient
  assign op_a = ctrl_i.mul_sel ? coef_i : x_q;
  assign op_b = ctrl_i.mul_sel ? y_q    : x_q;
  assign prod = ProdW'(op_a) * ProdW'(op_b);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      if (ctrl_i.x_ce) x_q <= x_i;
      if (ctrl_i.y_ce) y_q <= prod[KeepHi:FRAC_W];
    end
  end

  assign y_o = y_q;
endmodule

// File: rtl/coef_square_calc.sv
module coef_square_calc
  import csq_pkg::*;
#(
  parameter int DATA_W = 20,
  parameter int FRAC_W = 12,
  parameter int IDX_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              load_en_i,
  input  logic [IDX_W-1:0]  load_addr_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [DATA_W-1:0] y_o,
  output logic              done_o
);
  csq_ctrl_t   ctrl;
  csq_state_e  state;
  logic [IDX_W-1:0]  ram_addr;
  logic [DATA_W-1:0] coef;
  logic signed [DATA_W-1:0] y_s;

  assign ram_addr = load_en_i ? load_addr_i : idx_i;

  csq_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .ctrl_o  (ctrl),
    .state_o (state),
    .done_o  (done_o)
  );

  csq_coef_ram #(.DATA_W(DATA_W), .ADDR_W(IDX_W)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl.ram_en),
    .wr_i   (load_en_i),
    .addr_i (ram_addr),
    .din_i  (load_data_i),
    .dout_o (coef)
  );

  csq_datapath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_dp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctrl_i (ctrl),
    .x_i    (x_i),
    .coef_i (coef),
    .y_o    (y_s)
  );

  assign y_o = y_s;

  a_r6_y_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_CAPTURE) |=> $stable(y_o));
  a_r2_done_after_scale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(state) == ST_SCALE));
endmodule

// File: tb/coef_square_calc_bench.sv
module coef_square_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] x = '0;
  logic [11:0] idx = '0;
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [19:0] ld_data = '0;
  logic [19:0] y;
  logic        done;

  int checks = 0;
  int fails  = 0;
  logic signed [19:0] tbl [4096];

  always #10 clk = ~clk;

  coef_square_calc u_coef_square_calc (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .x_i(x), .idx_i(idx),
    .load_en_i(ld_en), .load_addr_i(ld_addr), .load_data_i(ld_data),
    .y_o(y), .done_o(done)
  );

  function automatic logic signed [19:0] fx_mul(input logic signed [19:0] a,
                                                input logic signed [19:0] b);
    logic signed [39:0] p;
    p = 40'(a) * 40'(b);
    return p[31:12];
  endfunction

  function automatic logic signed [19:0] model(input logic signed [19:0] xv,
                                               input logic signed [19:0] c);
    return fx_mul(c, fx_mul(xv, xv));
  endfunction

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [11:0] a, input logic signed [19:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
    tbl[a] = d;
  endtask

  // one request; done and result checked two edges after acceptance (R2, R3)
  task automatic run_op(input string tag, input logic signed [19:0] xv,
                        input logic [11:0] iv);
    @(negedge clk);
    start = 1'b1; x = xv; idx = iv;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R2 busy no done"}, {19'd0, done}, 20'd0);
    @(negedge clk);
    @(negedge clk);
    chk({tag, " R2 done high"}, {19'd0, done}, 20'd1);
    chk({tag, " R3 result"}, y, model(xv, tbl[iv]));
    @(negedge clk);
    chk({tag, " R2 done one cycle"}, {19'd0, done}, 20'd0);
  endtask

  task automatic t_reset;
    chk("R1 y reset", y, 20'd0);
    chk("R1 done reset", {19'd0, done}, 20'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 y after release", y, 20'd0);
    chk("R1 done after release", {19'd0, done}, 20'd0);
  endtask

  task automatic t_basic;
    load(12'd5, 20'sd8192);
    load(12'd100, -20'sd6144);
    load(12'd4095, 20'h7FFFF);
    run_op("basic", 20'sd6144, 12'd5);
    run_op("neg coef", 20'sd10240, 12'd100);
    run_op("max coef", 20'sd4096, 12'd4095);
  endtask

  task automatic t_trunc;
    load(12'd7, -20'sd3);
    run_op("R4 neg floor", -20'sd1000, 12'd7);
    run_op("R4 tiny", -20'sd1, 12'd7);
    run_op("R4 wrap", 20'sd409600, 12'd5);
    chk("R4 wrap value", y, model(20'sd409600, 20'sd8192));
  endtask

  task automatic t_busy_ignore;
    logic [19:0] exp;
    exp = model(20'sd5000, tbl[5]);
    @(negedge clk); start = 1'b1; x = 20'sd5000; idx = 12'd5;
    @(negedge clk); x = 20'sd777; idx = 12'd100;
    @(negedge clk); x = -20'sd9;
    @(negedge clk); start = 1'b0;
    chk("R5 busy inputs ignored", y, exp);
    @(negedge clk);
    chk("R5 no extra done", {19'd0, done}, 20'd0);
    repeat (3) @(negedge clk);
    chk("R5 no extra done later", {19'd0, done}, 20'd0);
    chk("R6 y held idle", y, exp);
  endtask

  task automatic t_load_then_start;
    @(negedge clk); ld_en = 1'b1; ld_addr = 12'd42; ld_data = 20'sd12288;
    @(negedge clk); ld_en = 1'b0; tbl[42] = 20'sd12288;
    start = 1'b1; x = 20'sd2048; idx = 12'd42;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R7 next-edge read sees new word", y, model(20'sd2048, 20'sd12288));
  endtask

  task automatic t_load_busy;
    @(negedge clk); start = 1'b1; x = 20'sd4096; idx = 12'd5;
    @(negedge clk); start = 1'b0; ld_en = 1'b1; ld_addr = 12'd5; ld_data = 20'sd99;
    @(negedge clk);
    @(negedge clk); ld_en = 1'b0;
    run_op("R8 busy load ignored", 20'sd4096, 12'd5);
  endtask

  task automatic t_load_and_start;
    @(negedge clk);
    start = 1'b1; x = 20'sd3000; idx = 12'd5;
    ld_en = 1'b1; ld_addr = 12'd300; ld_data = -20'sd20000;
    @(negedge clk); start = 1'b0; ld_en = 1'b0; tbl[300] = -20'sd20000;
    @(negedge clk); @(negedge clk);
    chk("R9 coef from load data", y, model(20'sd3000, -20'sd20000));
    run_op("R9 stored at load addr", 20'sd3000, 12'd300);
  endtask

  task automatic t_streaming;
    @(negedge clk); start = 1'b1; x = 20'sd1500; idx = 12'd5;
    repeat (3) @(negedge clk);
    chk("R10 first done", {19'd0, done}, 20'd1);
    chk("R10 first result", y, model(20'sd1500, tbl[5]));
    x = -20'sd2500; idx = 12'd100;
    repeat (3) @(negedge clk);
    chk("R10 second done", {19'd0, done}, 20'd1);
    chk("R10 second result", y, model(-20'sd2500, tbl[100]));
    start = 1'b0;
    @(negedge clk);
    chk("R10 stops after release", {19'd0, done}, 20'd0);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_trunc();
    t_busy_ignore();
    t_load_then_start();
    t_load_busy();
    t_load_and_start();
    t_streaming();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule